// File: doc/BRIEF.md
# Snooping Write-Back Cache Controller

This block is the per-processor controller of a small direct-mapped, write-back cache that keeps itself coherent by watching a shared bus. Each line records one of three coherence states: invalid, shared (clean and read-only), or exclusive (the single copy, writable, and newer than memory). The processor side is a simple request port that is held until `cpuReady`. On a miss the controller requests the bus. If needed, it first writes back a dirty victim. It then issues a read-miss or write-miss, installs the returned word and lets the request complete as a hit.

Transactions from the other caches arrive on the snoop port. A snooped write-miss invalidates a matching line. A snooped miss to a line held exclusive makes this cache hand out its dirty word with `snpSupply` set, which tells the memory to drop its own reply. The line then drops to shared on a read-miss, or to invalid on a write-miss. Bus arbitration and memory live outside the block. Each block holds one data word.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is invalid: `cpuReady`, `busReq` and `snpSupply` are low, and the first read of any address goes to the bus.
- R2: A read that does not find a valid line with a matching tag requests the bus and, once granted, issues command 1 (read-miss) with `cpuAddr`. It installs the word from `busDataIn` as shared and then returns it on `cpuRdata`.
- R3: A read of a shared or exclusive line with a matching tag completes in the cycle it is presented, with no bus request.
- R4: A write to an invalid line issues command 2 (write-miss), installs the line as exclusive, and then stores `cpuWdata`.
- R5: A write to an exclusive line with a matching tag completes in its first cycle with no bus transaction, and later reads return the new word.
- R6: A write to a shared line with a matching tag is handled as a write-miss (command 2), after which the line is exclusive.
- R7: A miss whose index holds an exclusive line with another tag first issues command 3 (write-back) carrying that line's address and word. Then it issues the read-miss or write-miss for the new address.
- R8: A snooped command 1 that matches an exclusive line raises `snpSupply` with the line's word on `snpData` in the same cycle. The line becomes shared: reads still hit, and a write needs a write-miss.
- R9: A snooped command 2 that matches an exclusive line raises `snpSupply` with the word, and the line becomes invalid.
- R10: A snooped command 2 that matches a shared line invalidates it without raising `snpSupply`.
- R11: Snoops to invalid lines or to other tags, command 1 to a shared line, and command 3 of any kind leave `snpSupply` low and change no line.
- R12: A snoop in the same cycle as a processor request is served first; `cpuReady` stays low in that cycle.
- R13: `busReq` stays high from the cycle after a miss is seen until the word is installed, and `cpuReady` is never high while `busReq` is. A plain miss completes three cycles after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request valid, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address: low IDX_W bits index, rest tag |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid with `cpuReady` on a read |
| cpuReady | output | 1 | Request completes at this clock edge |
| busReq | output | 1 | Bus wanted for a miss |
| busGnt | input | 1 | Bus granted |
| busCmdOut | output | 2 | 0 none, 1 read-miss, 2 write-miss, 3 write-back |
| busAddrOut | output | ADDR_W | Address of the issued command |
| busDataOut | output | DATA_W | Word carried by a write-back |
| busDone | input | 1 | Current command finished; miss data valid |
| busDataIn | input | DATA_W | Word returned for a miss |
| snpValid | input | 1 | Another cache's command is on the bus |
| snpCmd | input | 2 | Snooped command, same coding as `busCmdOut` |
| snpAddr | input | ADDR_W | Snooped address |
| snpSupply | output | 1 | This cache supplies the word; memory reply cancelled |
| snpData | output | DATA_W | Word supplied with `snpSupply` |

## Verification
The bench replaces a dirty line of each index by a read and by a write. A controller that skipped the write-back would lose the dirty word, which shows up in the bench memory and in the bus log. It writes to a freshly shared line, where an upgrade without a bus command would let a stale copy survive elsewhere. The bench also snoops misses onto exclusive, shared, mismatched and invalid lines. Supplying from a clean line, or missing a downgrade, would show as a wrong `snpSupply` value or a read that still hits. Finally it presents a snoop and a processor read together; a design that served both would raise `cpuReady` in the cycle the snoop owns.

// File: rtl/snoop_cache_pkg.sv
package snoop_cache_pkg;

  typedef enum logic [1:0] {
    LINE_INV = 2'b00,
    LINE_SHR = 2'b01,
    LINE_EXC = 2'b10
  } lineState_t;

  typedef enum logic [1:0] {
    BUS_NONE   = 2'd0,
    BUS_RDMISS = 2'd1,
    BUS_WRMISS = 2'd2,
    BUS_WRBACK = 2'd3
  } busCmd_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic install;     // load tag/state/word at the processor index
    logic installExc;  // installed line is exclusive (else shared)
    logic cpuWrite;    // store processor word on a write hit
    logic snpUpdate;   // change state of the snooped line
    logic snpToShared; // snooped line becomes shared (else invalid)
    logic selVictim;   // bus address/data come from the resident line
  } ctrlStrobe_t;

endpackage

// File: rtl/snoop_cache_dp.sv
module snoop_cache_dp
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [DATA_W-1:0] busDataIn,
  output lineState_t        cpuSt,
  output logic              cpuTagEq,
  output lineState_t        snpSt,
  output logic              snpTagEq,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] snpData,
  output logic [ADDR_W-1:0] busAddrOut,
  output logic [DATA_W-1:0] busDataOut
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  lineState_t        stateArr [LINES];
  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [DATA_W-1:0] dataArr  [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    lineState_t        stQ;
    logic [TAG_W-1:0]  tagQ;
    logic [DATA_W-1:0] dataQ;
    logic              cpuSel, snpSel;

    assign cpuSel = (cpuIdx == IDX_W'(g));
    assign snpSel = (snpIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stQ   <= LINE_INV;
        tagQ  <= '0;
        dataQ <= '0;
      end else begin
        if (strobe.snpUpdate && snpSel)
          stQ <= strobe.snpToShared ? LINE_SHR : LINE_INV;
        if (strobe.install && cpuSel) begin
          stQ   <= strobe.installExc ? LINE_EXC : LINE_SHR;
          tagQ  <= cpuTag;
          dataQ <= busDataIn;
        end else if (strobe.cpuWrite && cpuSel) begin
          dataQ <= cpuWdata;
        end
      end
    end

    assign stateArr[g] = stQ;
    assign tagArr[g]   = tagQ;
    assign dataArr[g]  = dataQ;
  end

  assign cpuSt    = stateArr[cpuIdx];
  assign cpuTagEq = (tagArr[cpuIdx] == cpuTag);
  assign snpSt    = stateArr[snpIdx];
  assign snpTagEq = (tagArr[snpIdx] == snpTag);
  assign cpuRdata = dataArr[cpuIdx];
  assign snpData  = dataArr[snpIdx];

  assign busAddrOut = strobe.selVictim ? {tagArr[cpuIdx], cpuIdx} : cpuAddr;
  assign busDataOut = strobe.selVictim ? dataArr[cpuIdx] : '0;

endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
  import snoop_cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  lineState_t  cpuSt,
  input  logic        cpuTagEq,
  input  logic        snpValid,
  input  busCmd_t     snpCmd,
  input  lineState_t  snpSt,
  input  logic        snpTagEq,
  input  logic        busGnt,
  input  logic        busDone,
  output ctrlStrobe_t strobe,
  output logic        cpuReady,
  output logic        busReq,
  output busCmd_t     busCmd,
  output logic        snpSupply
);
  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WB, PH_MISS} phase_t;

  phase_t phQ, phNext;
  logic   localHit, snpMatch, snpWindow;

  assign localHit  = cpuTagEq && (cpuWe ? (cpuSt == LINE_EXC) : (cpuSt != LINE_INV));
  assign snpWindow = (phQ == PH_IDLE) || (phQ == PH_REQ);
  assign snpMatch  = snpValid && snpWindow && snpTagEq && (snpSt != LINE_INV);

  always_comb begin
    strobe    = '0;
    cpuReady  = 1'b0;
    busCmd    = BUS_NONE;
    snpSupply = 1'b0;
    phNext    = phQ;

    if (snpMatch) begin
      unique case (snpCmd)
        BUS_RDMISS: if (snpSt == LINE_EXC) begin
          snpSupply          = 1'b1;
          strobe.snpUpdate   = 1'b1;
          strobe.snpToShared = 1'b1;
        end
        BUS_WRMISS: begin
          snpSupply        = (snpSt == LINE_EXC);
          strobe.snpUpdate = 1'b1;
        end
        default: ;
      endcase
    end

    unique case (phQ)
      PH_IDLE: if (cpuReq && !snpValid) begin
        if (localHit) begin
          cpuReady        = 1'b1;
          strobe.cpuWrite = cpuWe;
        end else begin
          phNext = PH_REQ;
        end
      end
      PH_REQ: if (busGnt)
        phNext = (cpuSt == LINE_EXC && !cpuTagEq) ? PH_WB : PH_MISS;
      PH_WB: begin
        busCmd           = BUS_WRBACK;
        strobe.selVictim = 1'b1;
        if (busDone) phNext = PH_MISS;
      end
      PH_MISS: begin
        busCmd = cpuWe ? BUS_WRMISS : BUS_RDMISS;
        if (busDone) begin
          strobe.install    = 1'b1;
          strobe.installExc = cpuWe;
          phNext            = PH_IDLE;
        end
      end
      default: phNext = PH_IDLE;
    endcase
  end

  assign busReq = (phQ != PH_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phQ <= PH_IDLE;
    else       phQ <= phNext;
  end

endmodule

// File: rtl/snoop_cache.sv
module snoop_cache
  import snoop_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmdOut,
  output logic [ADDR_W-1:0] busAddrOut,
  output logic [DATA_W-1:0] busDataOut,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpSupply,
  output logic [DATA_W-1:0] snpData
);
  ctrlStrobe_t strobe;
  lineState_t  cpuSt, snpSt;
  logic        cpuTagEq, snpTagEq;
  busCmd_t     busCmd;

  snoop_cache_dp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .snpAddr(snpAddr), .busDataIn(busDataIn),
    .cpuSt(cpuSt), .cpuTagEq(cpuTagEq), .snpSt(snpSt), .snpTagEq(snpTagEq),
    .cpuRdata(cpuRdata), .snpData(snpData),
    .busAddrOut(busAddrOut), .busDataOut(busDataOut)
  );

  snoop_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuSt(cpuSt), .cpuTagEq(cpuTagEq),
    .snpValid(snpValid), .snpCmd(busCmd_t'(snpCmd)), .snpSt(snpSt), .snpTagEq(snpTagEq),
    .busGnt(busGnt), .busDone(busDone),
    .strobe(strobe), .cpuReady(cpuReady), .busReq(busReq), .busCmd(busCmd),
    .snpSupply(snpSupply)
  );

  assign busCmdOut = busCmd;

endmodule

// File: rtl/snoop_cache_chk.sv
module snoop_cache_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuReady,
  input logic              busReq,
  input logic [1:0]        busCmdOut,
  input logic              busDone,
  input logic              snpValid,
  input logic [1:0]        snpCmd,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              snpSupply
);
  // R12
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuReady && snpValid));

  // R13
  ready_bus_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> (!busReq && cpuReq));

  // R13
  cmd_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdOut != 2'd0) |-> busReq);

  // R7
  wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCmdOut == 2'd3 && busDone) |=> (busCmdOut == 2'd1 || busCmdOut == 2'd2));

  // R9
  wr_snoop_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd2 && snpSupply) |=>
      !(snpValid && snpAddr == $past(snpAddr) && snpSupply));

  // R11
  wb_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpCmd == 2'd3) |-> !snpSupply);

  // R1
  supply_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpSupply |-> snpValid);

endmodule

bind snoop_cache snoop_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuReady(cpuReady),
  .busReq(busReq), .busCmdOut(busCmdOut), .busDone(busDone),
  .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr), .snpSupply(snpSupply)
);

// File: tb/snoop_cache_bench.sv
`timescale 1ns/1ps
module snoop_cache_bench;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          cpuReq = 0, cpuWe = 0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic [DW-1:0] cpuRdata;
  logic          cpuReady, busReq, busGnt;
  logic [1:0]    busCmdOut;
  logic [AW-1:0] busAddrOut;
  logic [DW-1:0] busDataOut;
  logic          busDone = 0;
  logic [DW-1:0] busDataIn = '0;
  logic          snpValid = 0;
  logic [1:0]    snpCmd = '0;
  logic [AW-1:0] snpAddr = '0;
  logic          snpSupply;
  logic [DW-1:0] snpData;

  snoop_cache u_snoop_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .busReq(busReq), .busGnt(busGnt), .busCmdOut(busCmdOut), .busAddrOut(busAddrOut),
    .busDataOut(busDataOut), .busDone(busDone), .busDataIn(busDataIn),
    .snpValid(snpValid), .snpCmd(snpCmd), .snpAddr(snpAddr),
    .snpSupply(snpSupply), .snpData(snpData)
  );

  logic [DW-1:0]      mem  [256];
  logic [DW-1:0]      refv [256];
  logic [DW-1:0]      expQ [$];
  logic [AW+DW+1:0]   busQ [$];
  string curTag = "R2";
  int checks = 0, errors = 0;
  bit finished = 0;

  assign busGnt = busReq;

  // memory / bus responder
  always @(negedge clk) begin
    if (busCmdOut != 2'd0 && !busDone) begin
      busQ.push_back({busCmdOut, busAddrOut, busDataOut});
      if (busCmdOut == 2'd3) mem[busAddrOut] = busDataOut;
      else busDataIn = mem[busAddrOut];
      busDone = 1'b1;
    end else begin
      busDone = 1'b0;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (rstN && cpuReq && cpuReady && !cpuWe) begin
      if (expQ.size() == 0) chk(curTag, "unexpected read", 1, 0);
      else chk(curTag, "read data", int'(cpuRdata), int'(expQ.pop_front()));
    end
  end

  task automatic cpuOp(input string tag, input bit we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int waitCyc);
    @(negedge clk);
    curTag = tag;
    cpuReq = 1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    if (!we) expQ.push_back(refv[a]);
    waitCyc = 0;
    #1;
    while (!cpuReady) begin
      @(negedge clk);
      #1;
      waitCyc++;
    end
    if (we) refv[a] = d;
    @(negedge clk);
    cpuReq = 0;
  endtask

  task automatic busChk(input string tag, input logic [1:0] cmd, input logic [AW-1:0] a,
                        input bit chkData, input logic [DW-1:0] d);
    logic [AW+DW+1:0] e;
    if (busQ.size() == 0) begin
      chk(tag, "bus command missing", 0, 1);
    end else begin
      e = busQ.pop_front();
      chk(tag, "bus command", int'(e[AW+DW+1:AW+DW]), int'(cmd));
      chk(tag, "bus address", int'(e[AW+DW-1:DW]), int'(a));
      if (chkData) chk(tag, "write-back word", int'(e[DW-1:0]), int'(d));
    end
  endtask

  task automatic noBus(input string tag);
    chk(tag, "bus commands issued", busQ.size(), 0);
    busQ.delete();
  endtask

  task automatic snoop(input string tag, input logic [1:0] cmd, input logic [AW-1:0] a,
                       input bit expSup, input logic [DW-1:0] expData);
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpAddr = a;
    #1;
    chk(tag, "snoop supply", int'(snpSupply), int'(expSup));
    if (expSup) begin
      chk(tag, "snoop word", int'(snpData), int'(expData));
      mem[a] = snpData;
    end
    @(negedge clk);
    snpValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    int w;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = DW'(16'h0100 + i * 3);
      refv[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "cpuReady in reset", int'(cpuReady), 0);
    chk("R1", "busReq in reset", int'(busReq), 0);
    chk("R1", "snpSupply in reset", int'(snpSupply), 0);
    rstN = 1;

    // R1 / R2: cold read miss
    cpuOp("R2", 0, 8'h04, '0, w);
    busChk("R2", 2'd1, 8'h04, 0, '0);
    noBus("R1");
    chk("R13", "miss latency", w, 3);

    // R3: read hit on shared
    cpuOp("R3", 0, 8'h04, '0, w);
    chk("R3", "hit latency", w, 0);
    noBus("R3");

    // R6: write to shared line is a write-miss
    cpuOp("R6", 1, 8'h04, 16'hAAAA, w);
    busChk("R6", 2'd2, 8'h04, 0, '0);
    noBus("R6");
    cpuOp("R5", 0, 8'h04, '0, w);
    noBus("R5");

    // R5: write hit on exclusive
    cpuOp("R5", 1, 8'h04, 16'hBBBB, w);
    chk("R5", "write hit latency", w, 0);
    noBus("R5");
    cpuOp("R5", 0, 8'h04, '0, w);

    // R4: write to invalid line
    cpuOp("R4", 1, 8'h09, 16'h1234, w);
    busChk("R4", 2'd2, 8'h09, 0, '0);
    noBus("R4");
    cpuOp("R4", 0, 8'h09, '0, w);
    noBus("R4");

    // R7: replace dirty line on a read
    cpuOp("R7", 0, 8'h08, '0, w);
    busChk("R7", 2'd3, 8'h04, 1, 16'hBBBB);
    busChk("R7", 2'd1, 8'h08, 0, '0);
    noBus("R7");
    chk("R7", "memory after write-back", int'(mem[8'h04]), 16'hBBBB);

    // R7: replace dirty line on a write
    cpuOp("R7", 1, 8'h0D, 16'h5555, w);
    busChk("R7", 2'd3, 8'h09, 1, 16'h1234);
    busChk("R7", 2'd2, 8'h0D, 0, '0);
    noBus("R7");

    // R8: snooped read-miss to exclusive
    snoop("R8", 2'd1, 8'h0D, 1, 16'h5555);
    cpuOp("R8", 0, 8'h0D, '0, w);
    noBus("R8");
    cpuOp("R8", 1, 8'h0D, 16'h6666, w);
    busChk("R8", 2'd2, 8'h0D, 0, '0);
    noBus("R8");

    // R9: snooped write-miss to exclusive
    snoop("R9", 2'd2, 8'h0D, 1, 16'h6666);
    mem[8'h0D] = 16'h7777; refv[8'h0D] = 16'h7777;
    cpuOp("R9", 0, 8'h0D, '0, w);
    busChk("R9", 2'd1, 8'h0D, 0, '0);
    noBus("R9");

    // R10: snooped write-miss to shared
    snoop("R10", 2'd2, 8'h0D, 0, '0);
    mem[8'h0D] = 16'h7878; refv[8'h0D] = 16'h7878;
    cpuOp("R10", 0, 8'h0D, '0, w);
    busChk("R10", 2'd1, 8'h0D, 0, '0);
    noBus("R10");

    // R11: snoops that must do nothing (line 0x08 shared)
    snoop("R11", 2'd1, 8'h08, 0, '0);
    snoop("R11", 2'd2, 8'h0C, 0, '0);
    snoop("R11", 2'd2, 8'h02, 0, '0);
    snoop("R11", 2'd3, 8'h08, 0, '0);
    cpuOp("R11", 0, 8'h08, '0, w);
    noBus("R11");
    cpuOp("R11", 1, 8'h08, 16'h4242, w);
    busChk("R11", 2'd2, 8'h08, 0, '0);
    noBus("R11");
    snoop("R11", 2'd3, 8'h08, 0, '0);
    cpuOp("R11", 1, 8'h08, 16'h4343, w);
    noBus("R11");

    // R12: snoop and processor request in the same cycle
    @(negedge clk);
    curTag = "R12";
    cpuReq = 1; cpuWe = 0; cpuAddr = 8'h08;
    expQ.push_back(refv[8'h08]);
    snpValid = 1; snpCmd = 2'd1; snpAddr = 8'h0C;
    #1;
    chk("R12", "cpuReady during snoop", int'(cpuReady), 0);
    chk("R12", "snpSupply on mismatch", int'(snpSupply), 0);
    @(negedge clk);
    snpValid = 0;
    #1;
    chk("R12", "cpuReady after snoop", int'(cpuReady), 1);
    @(negedge clk);
    cpuReq = 0;
    noBus("R12");

    repeat (3) @(negedge clk);
    chk("R12", "scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule